// File: doc/BRIEF.md
# Target-Abort Error Reporter

This block sits next to a PCI/PCI-X bus initiator and watches for outbound transactions that end in a target abort. It recognises two kinds of abort. One is a direct abort seen on the bus handshake lines. The other, in PCI-X mode only, is a split completion error message forwarded by a bridge that reports a target abort on its far side.

For each abort it records sticky error status and, where the mask and enable controls allow, interrupt status. It raises SERR# for aborted MSI writes when system-error signalling is enabled. It also produces two one-cycle strobes: one ends an outstanding read completion on the internal bus, and the other asks the outbound queue to drop the aborted entry.

Every status and interrupt-status bit stays set until software writes a one to it. If a new event and a clear arrive together, the event takes precedence. Detection is edge-qualified, so an abort condition that stays present for several cycles is reported only once.

Top module: `tabort_reporter`

## Requirements
- R1: A direct abort is the sampled condition `bus_devsel_n`=1, `bus_trdy_n`=1, `bus_stop_n`=0. In either bus mode it sets `sts` bit 12 (TA_BIT) in the cycle after the condition is first seen.
- R2: A split message with `scm_valid`=1, `scm_class`=1 and `scm_index`=1 while `pcix_mode`=1 is an abort. It sets `sts` bit 12 and `scm_sts`. The same message in conventional mode, or with any other class or index, changes no output.
- R3: Interrupt-status bit 0 (`isr[0]`, target abort) is set on an abort only when `ta_mask`=0.
- R4: `serr_n` goes low for exactly one cycle, in the cycle after detection. This happens only when the aborted transaction is an MSI write (`txn_write`=1 and `txn_msi`=1) and `serr_en`=1.
- R5: When SERR# fires, `sts` bit 14 (SERR_BIT) is set. `isr[1]` is set if `serr_mask`=0, and `isr[2]` is set if `serr_det_ie`=1.
- R6: On an abort that arrives through a split message, `isr[3]` is set when `scm_mask`=0.
- R7: `rd_abort` pulses for one cycle, in the cycle after detection, only when `txn_read`=1.
- R8: `oq_flush` pulses for one cycle, in the cycle after detection, on every abort.
- R9: `sts`, `isr` and `scm_sts` are sticky. They are cleared by writing a one through `sts_clr_we`/`sts_clr_data`, `isr_clr_we`/`isr_clr_data` and `scm_clr`. If a set and a clear fall in the same cycle, the bit ends up set.
- R10: An abort condition held for several cycles gives one set of updates and one strobe. Clearing a bit while the condition is still held does not set the bit again.
- R11: After reset, `sts`, `isr` and `scm_sts` are zero, `serr_n` is 1, and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_devsel_n | input | 1 | Sampled DEVSEL#, active low |
| bus_trdy_n | input | 1 | Sampled TRDY#, active low |
| bus_stop_n | input | 1 | Sampled STOP#, active low |
| pcix_mode | input | 1 | 1 = PCI-X mode, 0 = conventional mode |
| scm_valid | input | 1 | A split completion error message is present this cycle |
| scm_class | input | CLASS_W | Message class field |
| scm_index | input | INDEX_W | Message index field |
| txn_read | input | 1 | The current outbound transaction is a read |
| txn_write | input | 1 | The current outbound transaction is a write |
| txn_msi | input | 1 | The current write is an MSI |
| serr_en | input | 1 | SERR# signalling enable |
| serr_det_ie | input | 1 | Enable for the SERR#-detected interrupt status |
| ta_mask | input | 1 | Mask for the target-abort interrupt status |
| serr_mask | input | 1 | Mask for the SERR#-asserted interrupt status |
| scm_mask | input | 1 | Mask for the split-message interrupt status |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for `sts` |
| sts_clr_data | input | STS_W | Bits of `sts` to clear |
| isr_clr_we | input | 1 | Write-one-to-clear strobe for `isr` |
| isr_clr_data | input | 4 | Bits of `isr` to clear |
| scm_clr | input | 1 | Clears `scm_sts` |
| sts | output | STS_W | Error status (bit 12 target abort, bit 14 SERR# asserted) |
| isr | output | 4 | Interrupt status (0 abort, 1 SERR# asserted, 2 SERR# detected, 3 split message) |
| scm_sts | output | 1 | Split completion error message received |
| serr_n | output | 1 | SERR#, active low, one-cycle pulse |
| rd_abort | output | 1 | Ends the internal read completion |
| oq_flush | output | 1 | Flushes the outbound queue entry |

## Verification
The bench uses the default parameters: a 16-bit status register with the abort flag at bit 12 and the SERR# flag at bit 14, a 4-bit class and an 8-bit index, and class 1 with index 1 as the match. These values put both abort sources, all four interrupt-status bits and the mode gate within reach of directed tests. Those tests cover every mask and enable setting in both states and the mismatched-index case. They also cover a condition held for several cycles, and a clear that lands in the same cycle as a new abort, where the set must win.

// File: rtl/tabort_pkg.sv
package tabort_pkg;

    localparam int ISR_W = 4;

    typedef struct packed {
        logic hit;
        logic via_scm;
        logic is_read;
        logic is_msiw;
    } abort_evt_t;

    typedef struct packed {
        logic scm;
        logic sdet;
        logic serr;
        logic ta;
    } isr_bits_t;

    function automatic logic handshake_abort(input logic devsel_n,
                                             input logic trdy_n,
                                             input logic stop_n);
        return devsel_n & trdy_n & ~stop_n;
    endfunction

endpackage

// File: rtl/tabort_detect.sv
module tabort_detect
    import tabort_pkg::*;
#(
    parameter int CLASS_W  = 4,
    parameter int INDEX_W  = 8,
    parameter int CLASS_TA = 1,
    parameter int INDEX_TA = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               devsel_n,
    input  logic               trdy_n,
    input  logic               stop_n,
    input  logic               pcix_mode,
    input  logic               scm_valid,
    input  logic [CLASS_W-1:0] scm_class,
    input  logic [INDEX_W-1:0] scm_index,
    input  logic               txn_read,
    input  logic               txn_write,
    input  logic               txn_msi,
    output abort_evt_t         evt
);
    localparam int NSRC = 2;
    localparam logic [CLASS_W-1:0] CLS = CLASS_W'(CLASS_TA);
    localparam logic [INDEX_W-1:0] IDX = INDEX_W'(INDEX_TA);

    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] lvl_q;
    logic [NSRC-1:0] edge_hit;

    always_comb begin
        lvl[0] = handshake_abort(devsel_n, trdy_n, stop_n);
        lvl[1] = pcix_mode & scm_valid & (scm_class == CLS) & (scm_index == IDX);
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) lvl_q[g] <= 1'b0;
            else     lvl_q[g] <= lvl[g];
        end
        assign edge_hit[g] = lvl[g] & ~lvl_q[g];
    end

    always_comb begin
        evt.hit     = |edge_hit;
        evt.via_scm = edge_hit[1];
        evt.is_read = (|edge_hit) & txn_read;
        evt.is_msiw = (|edge_hit) & txn_write & txn_msi;
    end

endmodule

// File: rtl/tabort_resp.sv
module tabort_resp
    import tabort_pkg::*;
#(
    parameter int STS_W    = 16,
    parameter int TA_BIT   = 12,
    parameter int SERR_BIT = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  abort_evt_t       evt,
    input  logic             serr_en,
    input  logic             serr_det_ie,
    input  logic             ta_mask,
    input  logic             serr_mask,
    input  logic             scm_mask,
    output logic [STS_W-1:0] sts_set,
    output isr_bits_t        isr_set,
    output logic             scm_set,
    output logic             serr_n,
    output logic             rd_abort,
    output logic             oq_flush
);
    logic serr_fire;

    always_comb begin
        serr_fire         = evt.is_msiw & serr_en;
        sts_set           = '0;
        sts_set[TA_BIT]   = evt.hit;
        sts_set[SERR_BIT] = serr_fire;
        isr_set.ta        = evt.hit & ~ta_mask;
        isr_set.serr      = serr_fire & ~serr_mask;
        isr_set.sdet      = serr_fire & serr_det_ie;
        isr_set.scm       = evt.via_scm & ~scm_mask;
        scm_set           = evt.via_scm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            serr_n   <= 1'b1;
            rd_abort <= 1'b0;
            oq_flush <= 1'b0;
        end else begin
            serr_n   <= ~serr_fire;
            rd_abort <= evt.is_read;
            oq_flush <= evt.hit;
        end
    end

endmodule

// File: rtl/tabort_w1c.sv
module tabort_w1c #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_mask) | set;
    end

endmodule

// File: rtl/tabort_reporter.sv
module tabort_reporter
    import tabort_pkg::*;
#(
    parameter int STS_W    = 16,
    parameter int TA_BIT   = 12,
    parameter int SERR_BIT = 14,
    parameter int CLASS_W  = 4,
    parameter int INDEX_W  = 8,
    parameter int CLASS_TA = 1,
    parameter int INDEX_TA = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_devsel_n,
    input  logic               bus_trdy_n,
    input  logic               bus_stop_n,
    input  logic               pcix_mode,
    input  logic               scm_valid,
    input  logic [CLASS_W-1:0] scm_class,
    input  logic [INDEX_W-1:0] scm_index,
    input  logic               txn_read,
    input  logic               txn_write,
    input  logic               txn_msi,
    input  logic               serr_en,
    input  logic               serr_det_ie,
    input  logic               ta_mask,
    input  logic               serr_mask,
    input  logic               scm_mask,
    input  logic               sts_clr_we,
    input  logic [STS_W-1:0]   sts_clr_data,
    input  logic               isr_clr_we,
    input  logic [ISR_W-1:0]   isr_clr_data,
    input  logic               scm_clr,
    output logic [STS_W-1:0]   sts,
    output logic [ISR_W-1:0]   isr,
    output logic               scm_sts,
    output logic               serr_n,
    output logic               rd_abort,
    output logic               oq_flush
);
    abort_evt_t       evt;
    logic [STS_W-1:0] sts_set;
    isr_bits_t        isr_set;
    logic             scm_set;

    tabort_detect #(
        .CLASS_W (CLASS_W),
        .INDEX_W (INDEX_W),
        .CLASS_TA(CLASS_TA),
        .INDEX_TA(INDEX_TA)
    ) u_detect (
        .clk      (clk),
        .rst      (rst),
        .devsel_n (bus_devsel_n),
        .trdy_n   (bus_trdy_n),
        .stop_n   (bus_stop_n),
        .pcix_mode(pcix_mode),
        .scm_valid(scm_valid),
        .scm_class(scm_class),
        .scm_index(scm_index),
        .txn_read (txn_read),
        .txn_write(txn_write),
        .txn_msi  (txn_msi),
        .evt      (evt)
    );

    tabort_resp #(
        .STS_W   (STS_W),
        .TA_BIT  (TA_BIT),
        .SERR_BIT(SERR_BIT)
    ) u_resp (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .serr_en    (serr_en),
        .serr_det_ie(serr_det_ie),
        .ta_mask    (ta_mask),
        .serr_mask  (serr_mask),
        .scm_mask   (scm_mask),
        .sts_set    (sts_set),
        .isr_set    (isr_set),
        .scm_set    (scm_set),
        .serr_n     (serr_n),
        .rd_abort   (rd_abort),
        .oq_flush   (oq_flush)
    );

    tabort_w1c #(.W(STS_W)) u_sts (
        .clk(clk), .rst(rst), .set(sts_set),
        .clr_we(sts_clr_we), .clr_data(sts_clr_data), .q(sts)
    );

    tabort_w1c #(.W(ISR_W)) u_isr (
        .clk(clk), .rst(rst), .set(isr_set),
        .clr_we(isr_clr_we), .clr_data(isr_clr_data), .q(isr)
    );

    tabort_w1c #(.W(1)) u_scm (
        .clk(clk), .rst(rst), .set(scm_set),
        .clr_we(scm_clr), .clr_data(1'b1), .q(scm_sts)
    );

endmodule

// File: rtl/tabort_reporter_chk.sv
module tabort_reporter_chk #(
    parameter int STS_W    = 16,
    parameter int TA_BIT   = 12,
    parameter int SERR_BIT = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             txn_write,
    input logic             txn_msi,
    input logic             serr_en,
    input logic             ta_mask,
    input logic             pcix_mode,
    input logic [STS_W-1:0] sts,
    input logic [3:0]       isr,
    input logic             scm_sts,
    input logic             serr_n,
    input logic             rd_abort,
    input logic             oq_flush
);
    assert_serr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        !serr_n |=> serr_n);

    assert_serr_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(serr_n) |-> $past(serr_en && txn_write && txn_msi));

    assert_serr_sts_R5: assert property (@(posedge clk) disable iff (rst)
        !serr_n |-> sts[SERR_BIT]);

    assert_flush_sts_R8: assert property (@(posedge clk) disable iff (rst)
        oq_flush |-> sts[TA_BIT]);

    assert_rdabort_flush_R7: assert property (@(posedge clk) disable iff (rst)
        rd_abort |-> oq_flush);

    assert_isr_mask_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(isr[0]) |-> $past(!ta_mask));

    assert_scm_mode_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(scm_sts) |-> $past(pcix_mode));

endmodule

bind tabort_reporter tabort_reporter_chk #(
    .STS_W   (STS_W),
    .TA_BIT  (TA_BIT),
    .SERR_BIT(SERR_BIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .txn_write(txn_write),
    .txn_msi  (txn_msi),
    .serr_en  (serr_en),
    .ta_mask  (ta_mask),
    .pcix_mode(pcix_mode),
    .sts      (sts),
    .isr      (isr),
    .scm_sts  (scm_sts),
    .serr_n   (serr_n),
    .rd_abort (rd_abort),
    .oq_flush (oq_flush)
);

// File: tb/tabort_reporter_test.sv
`timescale 1ns/1ps
module tabort_reporter_test;
    localparam int STS_W = 16;
    localparam logic [15:0] B12 = 16'h1000;
    localparam logic [15:0] B14 = 16'h4000;

    logic clk = 1'b0;
    logic rst;
    logic devsel_n, trdy_n, stop_n, pcix_mode;
    logic scm_valid;
    logic [3:0] scm_class;
    logic [7:0] scm_index;
    logic txn_read, txn_write, txn_msi;
    logic serr_en, serr_det_ie, ta_mask, serr_mask, scm_mask;
    logic sts_clr_we;
    logic [STS_W-1:0] sts_clr_data;
    logic isr_clr_we;
    logic [3:0] isr_clr_data;
    logic scm_clr;
    logic [STS_W-1:0] sts;
    logic [3:0] isr;
    logic scm_sts, serr_n, rd_abort, oq_flush;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tabort_reporter uut (
        .clk(clk), .rst(rst),
        .bus_devsel_n(devsel_n), .bus_trdy_n(trdy_n), .bus_stop_n(stop_n),
        .pcix_mode(pcix_mode), .scm_valid(scm_valid),
        .scm_class(scm_class), .scm_index(scm_index),
        .txn_read(txn_read), .txn_write(txn_write), .txn_msi(txn_msi),
        .serr_en(serr_en), .serr_det_ie(serr_det_ie), .ta_mask(ta_mask),
        .serr_mask(serr_mask), .scm_mask(scm_mask),
        .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
        .isr_clr_we(isr_clr_we), .isr_clr_data(isr_clr_data), .scm_clr(scm_clr),
        .sts(sts), .isr(isr), .scm_sts(scm_sts), .serr_n(serr_n),
        .rd_abort(rd_abort), .oq_flush(oq_flush)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_idle();
        devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
        scm_valid = 1'b0; scm_class = '0; scm_index = '0;
        sts_clr_we = 1'b0; sts_clr_data = '0;
        isr_clr_we = 1'b0; isr_clr_data = '0; scm_clr = 1'b0;
    endtask

    task automatic set_ctl(input logic rd, input logic wr, input logic msi,
                           input logic sen, input logic sie, input logic tm,
                           input logic sm, input logic cm, input logic mode);
        txn_read = rd; txn_write = wr; txn_msi = msi;
        serr_en = sen; serr_det_ie = sie; ta_mask = tm;
        serr_mask = sm; scm_mask = cm; pcix_mode = mode;
    endtask

    task automatic clear_all();
        @(negedge clk);
        sts_clr_we = 1'b1; sts_clr_data = '1;
        isr_clr_we = 1'b1; isr_clr_data = '1; scm_clr = 1'b1;
        @(negedge clk);
        bus_idle();
    endtask

    // Drive a direct abort for one cycle; outputs checked one edge later.
    task automatic direct_abort();
        @(negedge clk);
        devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b0;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic scm_msg(input logic [3:0] cls, input logic [7:0] idx);
        @(negedge clk);
        scm_valid = 1'b1; scm_class = cls; scm_index = idx;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic t_reset();
        chk("R11", "sts", 32'(sts), 0);
        chk("R11", "isr", 32'(isr), 0);
        chk("R11", "scm_sts", 32'(scm_sts), 0);
        chk("R11", "serr_n", 32'(serr_n), 1);
        chk("R11", "strobes", {30'd0, rd_abort, oq_flush}, 0);
    endtask

    task automatic t_direct_read();
        set_ctl(1, 0, 0, 1, 1, 0, 0, 0, 0);
        direct_abort();
        chk("R1", "sts conv", 32'(sts), 32'(B12));
        chk("R3", "isr ta", 32'(isr), 32'h1);
        chk("R7", "rd_abort", 32'(rd_abort), 1);
        chk("R8", "oq_flush", 32'(oq_flush), 1);
        chk("R4", "serr_n read", 32'(serr_n), 1);
        @(negedge clk);
        chk("R8", "flush one cycle", {30'd0, rd_abort, oq_flush}, 0);
        chk("R9", "sticky", 32'(sts), 32'(B12));
        clear_all();
        chk("R9", "clear sts", 32'(sts), 0);
        chk("R9", "clear isr", 32'(isr), 0);
    endtask

    task automatic t_msi_serr();
        set_ctl(0, 1, 1, 1, 1, 0, 0, 0, 1);
        direct_abort();
        chk("R1", "sts pcix", 32'(sts), 32'(B12 | B14));
        chk("R5", "isr serr", 32'(isr), 32'h7);
        chk("R4", "serr_n low", 32'(serr_n), 0);
        chk("R7", "no rd_abort on write", 32'(rd_abort), 0);
        @(negedge clk);
        chk("R4", "serr_n high again", 32'(serr_n), 1);
        clear_all();
        set_ctl(0, 1, 1, 1, 0, 1, 1, 0, 1);
        direct_abort();
        chk("R5", "sts serr masked", 32'(sts), 32'(B12 | B14));
        chk("R3", "isr all masked", 32'(isr), 0);
        chk("R4", "serr_n masked isr", 32'(serr_n), 0);
        clear_all();
        set_ctl(0, 1, 1, 0, 1, 0, 0, 0, 1);
        direct_abort();
        chk("R4", "serr disabled", 32'(serr_n), 1);
        chk("R5", "no serr sts", 32'(sts), 32'(B12));
        chk("R5", "isr ta only", 32'(isr), 32'h1);
        clear_all();
        set_ctl(0, 1, 0, 1, 1, 0, 0, 0, 1);
        direct_abort();
        chk("R4", "plain write no serr", 32'(serr_n), 1);
        clear_all();
    endtask

    task automatic t_scm();
        set_ctl(0, 1, 0, 0, 0, 0, 0, 0, 1);
        scm_msg(4'h1, 8'h01);
        chk("R2", "sts scm", 32'(sts), 32'(B12));
        chk("R2", "scm_sts", 32'(scm_sts), 1);
        chk("R6", "isr scm", 32'(isr), 32'h9);
        chk("R8", "flush scm", 32'(oq_flush), 1);
        clear_all();
        set_ctl(1, 0, 0, 0, 0, 0, 0, 1, 1);
        scm_msg(4'h1, 8'h01);
        chk("R6", "scm masked isr", 32'(isr), 32'h1);
        chk("R7", "rd_abort scm", 32'(rd_abort), 1);
        clear_all();
        chk("R9", "scm cleared", 32'(scm_sts), 0);
        set_ctl(0, 1, 0, 0, 0, 0, 0, 0, 0);
        scm_msg(4'h1, 8'h01);
        chk("R2", "conv ignores scm", {15'd0, scm_sts, sts}, 0);
        chk("R2", "conv no flush", 32'(oq_flush), 0);
        set_ctl(0, 1, 0, 0, 0, 0, 0, 0, 1);
        scm_msg(4'h1, 8'h02);
        chk("R2", "other index ignored", {11'd0, oq_flush, isr, scm_sts, sts}, 0);
        scm_msg(4'h2, 8'h01);
        chk("R2", "other class ignored", {11'd0, oq_flush, isr, scm_sts, sts}, 0);
    endtask

    task automatic t_held();
        set_ctl(0, 1, 1, 1, 0, 0, 0, 0, 0);
        @(negedge clk);
        stop_n = 1'b0;
        @(negedge clk);
        chk("R10", "first flush", 32'(oq_flush), 1);
        chk("R10", "first serr", 32'(serr_n), 0);
        isr_clr_we = 1'b1; isr_clr_data = 4'hF;
        sts_clr_we = 1'b1; sts_clr_data = '1;
        @(negedge clk);
        isr_clr_we = 1'b0; sts_clr_we = 1'b0;
        chk("R10", "no second flush", 32'(oq_flush), 0);
        chk("R10", "no second serr", 32'(serr_n), 1);
        @(negedge clk);
        chk("R10", "held no re-set isr", 32'(isr), 0);
        chk("R10", "held no re-set sts", 32'(sts), 0);
        bus_idle();
        @(negedge clk);
    endtask

    task automatic t_set_wins();
        set_ctl(0, 1, 0, 0, 0, 0, 0, 0, 0);
        direct_abort();
        @(negedge clk);
        devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b0;
        sts_clr_we = 1'b1; sts_clr_data = '1;
        isr_clr_we = 1'b1; isr_clr_data = '1;
        @(negedge clk);
        bus_idle();
        chk("R9", "set wins sts", 32'(sts), 32'(B12));
        chk("R9", "set wins isr", 32'(isr), 32'h1);
        clear_all();
    endtask

    initial begin
        rst = 1'b1;
        bus_idle();
        set_ctl(0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direct_read();
        t_msi_serr();
        t_scm();
        t_held();
        t_set_wins();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule